// File: doc/BRIEF.md
# Multi-Lane Link Training Controller

This block brings up a four-lane serial link from the host end and decides how many lanes carry traffic. After reset it stays quiet for one cycle, then sends training sequences. It waits for the far end to echo them back on any lane. Once an echo is seen, the two ends exchange their active-lane masks and rate codes. The controller then settles in a four-lane mode, a two-lane mode or one of four single-lane modes, one for each lane. If a used lane stops showing its training flag, the controller steps down through recovery states instead of starting over.

Two upper-layer protocols share the same lanes. When a protocol switch is accepted, the controller saves the settled context of the protocol that was running: the mode, the lane mask, the width and the rate. It then strobes a PLL reset and waits for the PLL to lock again. If the protocol being switched to has already trained once, the controller goes straight back to its stored context without retraining. Otherwise it starts training from the quiet state.

Top module: `lane_train_ctrl`

## Requirements
- R1: While reset is low, and in the cycle after it is released, the state code reads 0, the width and rate outputs read 0, the PLL strobe and the switch-enable are low, and the active protocol reads 0.
- R2: State codes are: quiet 0, seek 1, discovery 2, four-lane 3, two-lane 4, single lane k is 5+k (k = 0 to 3), two-lane recovery 9, single-lane recovery 10, PLL reset 11, PLL wait 12. The quiet state lasts one cycle and is followed by seek. In seek, any set bit of `ts_seen` moves the controller to discovery on the next clock.
- R3: If no training flag is seen, seek lasts `seek_limit`+1 cycles and is followed by the quiet state.
- R4: In discovery, with `partner_valid` high, the common mask is `local_lanes & partner_lanes`. The controller returns to quiet if that mask is empty or if `partner_rate` is 0.
- R5: A common mask of 4 lanes gives the four-lane mode with width 4. A mask of 2 or 3 lanes gives the two-lane mode with width 2. In both cases the rate output is the smaller of `local_rate` and `partner_rate`.
- R6: A common mask of exactly one lane k gives single-lane state 5+k with width 1.
- R7: In the four-lane or two-lane mode, losing the flag on any used lane leads to two-lane recovery. From there the controller enters the two-lane mode if at least two used lanes still show flags, and single-lane recovery otherwise.
- R8: Single-lane recovery picks the lowest-numbered used lane that still shows its flag and enters that single-lane state. If there is none, it enters discovery. A single-lane mode that loses its lane enters discovery.
- R9: A `switch_req` seen in a mode state (codes 3 to 8) gives one cycle of the PLL reset state with `pll_rst` high, toggles the active protocol, then holds the PLL wait state until `pll_lock` rises. A `switch_req` in any other state has no effect.
- R10: When the lock rises, the stored context of the new protocol (state, width, rate) is restored directly. If that protocol has never been stored, the controller goes to the quiet state.
- R11: `switch_en` is high in mode states and low in every other state, including the PLL reset and PLL wait states.
- R12: While the controller stays in one mode state, the width and rate outputs do not change, whatever the local and partner inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_seen | input | 4 | Training-sequence detect flag, one per lane |
| local_lanes | input | 4 | Lanes this end can use |
| local_rate | input | 4 | Rate code this end supports |
| partner_valid | input | 1 | Partner's advertisement is present |
| partner_lanes | input | 4 | Lanes the partner advertises |
| partner_rate | input | 4 | Rate code the partner advertises (0 is invalid) |
| seek_limit | input | 16 | Seek timeout in cycles |
| switch_req | input | 1 | Request to change protocol |
| pll_lock | input | 1 | PLL lock indication |
| state_code | output | 4 | Current state |
| link_width | output | 16 | Negotiated lane count |
| link_rate | output | 4 | Negotiated rate code |
| pll_rst | output | 1 | One-cycle PLL reset strobe |
| switch_en | output | 1 | Link is in a stable mode |
| active_proto | output | 1 | Protocol currently using the link |

## Verification
Width negotiation is driven with mask pairs whose overlap is four lanes, three lanes, two lanes and single lanes at positions 0 to 3. Some of these pairs differ only in which bits overlap. This tells apart a lane count taken from the common mask from one taken from either side alone, and shows that the lowest common lane is picked rather than the lowest local lane. Disjoint masks and a zero partner rate check the fall-back to quiet. Recovery is driven by taking lanes away one step at a time, from four to three, then to one, then to none. A pair of protocol switches checks that a protocol trained once comes back with its own width and rate, while a protocol never trained goes back through training.

// File: rtl/ltc_pkg.sv
// Shared constants, state encoding and saved-context type for the link
// training controller. Assumes a four-lane link shared by two protocols.
package ltc_pkg;
    localparam int NLANE  = 4;
    localparam int NPROTO = 2;
    localparam int WID_W  = 16;
    localparam int RATE_W = 4;

    typedef enum logic [3:0] {
        ST_SILENT  = 4'd0,
        ST_SEEK    = 4'd1,
        ST_DISC    = 4'd2,
        ST_X4      = 4'd3,
        ST_X2      = 4'd4,
        ST_X1_L0   = 4'd5,
        ST_X1_L1   = 4'd6,
        ST_X1_L2   = 4'd7,
        ST_X1_L3   = 4'd8,
        ST_REC2    = 4'd9,
        ST_REC1    = 4'd10,
        ST_PLLRST  = 4'd11,
        ST_PLLWAIT = 4'd12
    } ltc_state_e;

    typedef struct packed {
        ltc_state_e         st;
        logic [NLANE-1:0]   mask;
        logic [WID_W-1:0]   width;
        logic [RATE_W-1:0]  rate;
    } ltc_ctx_t;

    // True for the settled operating modes (four-, two- or single-lane).
    function automatic logic is_mode(ltc_state_e s);
        return (s >= ST_X4) && (s <= ST_X1_L3);
    endfunction
endpackage

// File: rtl/ltc_lane_pick.sv
// Combinational lane selector: ANDs two lane masks, counts the common
// lanes and finds the lowest common lane. Assumes N >= 2.
module ltc_lane_pick #(
    parameter  int N  = 4,
    localparam int CW = $clog2(N + 1),
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  a,
    input  logic [N-1:0]  b,
    output logic [N-1:0]  both,
    output logic [CW-1:0] cnt,
    output logic [IW-1:0] low_idx,
    output logic [N-1:0]  low_hot
);
    logic found;

    // Count common lanes and mark the lowest one.
    always_comb begin
        both    = a & b;
        cnt     = '0;
        low_idx = '0;
        low_hot = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (both[i]) begin
                cnt = cnt + CW'(1);
                if (!found) begin
                    low_idx    = IW'(i);
                    low_hot[i] = 1'b1;
                    found      = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ltc_timer.sv
// Cycle counter for the seek window. It clears whenever run is low and
// reports expiry while running with the count equal to limit.
module ltc_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Count up while running and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q != limit) cnt_q <= cnt_q + TW'(1);
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/ltc_ctx_store.sv
// One saved link context per protocol, each with a valid flag. A write
// fills one entry; the read port is combinational.
module ltc_ctx_store
    import ltc_pkg::*;
#(
    parameter  int N  = NPROTO,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic [AW-1:0] wr_idx,
    input  ltc_ctx_t wr_ctx,
    input  logic [AW-1:0] rd_idx,
    output ltc_ctx_t rd_ctx,
    output logic     rd_ok
);
    ltc_ctx_t   ent [N];
    logic [N-1:0] ok;

    for (genvar g = 0; g < N; g++) begin : g_ent
        ltc_ctx_t ent_q;
        logic     ok_q;

        // Capture this entry when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
                ok_q  <= 1'b0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                ent_q <= wr_ctx;
                ok_q  <= 1'b1;
            end
        end

        assign ent[g] = ent_q;
        assign ok[g]  = ok_q;
    end

    assign rd_ctx = ent[rd_idx];
    assign rd_ok  = ok[rd_idx];
endmodule

// File: rtl/lane_train_ctrl.sv
// Link training controller for a four-lane link. It runs quiet, seek and
// discovery, picks a lane mode, steps down through recovery when lanes
// drop, and saves and restores a context per protocol across a PLL
// re-lock. Assumes inputs are synchronous to clk.
module lane_train_ctrl
    import ltc_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLANE-1:0]  ts_seen,
    input  logic [NLANE-1:0]  local_lanes,
    input  logic [RATE_W-1:0] local_rate,
    input  logic              partner_valid,
    input  logic [NLANE-1:0]  partner_lanes,
    input  logic [RATE_W-1:0] partner_rate,
    input  logic [TMR_W-1:0]  seek_limit,
    input  logic              switch_req,
    input  logic              pll_lock,
    output logic [3:0]        state_code,
    output logic [WID_W-1:0]  link_width,
    output logic [RATE_W-1:0] link_rate,
    output logic              pll_rst,
    output logic              switch_en,
    output logic              active_proto
);
    localparam int CNT_W = $clog2(NLANE + 1);
    localparam int IDX_W = $clog2(NLANE);

    ltc_state_e        state_q, state_d;
    logic [NLANE-1:0]  mask_q, mask_d;
    logic [WID_W-1:0]  width_q, width_d;
    logic [RATE_W-1:0] rate_q, rate_d;
    logic              proto_q, proto_d;
    logic              lock_q;
    logic              save;

    logic [NLANE-1:0]  pk_a, pk_b, pk_both, pk_hot;
    logic [CNT_W-1:0]  pk_cnt;
    logic [IDX_W-1:0]  pk_low;
    logic              tmr_exp;
    ltc_ctx_t          wr_ctx, rd_ctx;
    logic              rd_ok;
    logic              lane_drop;
    logic [RATE_W-1:0] rate_min;

    // The selector compares the advertisements in discovery and the live flags elsewhere.
    assign pk_a = (state_q == ST_DISC) ? local_lanes   : ts_seen;
    assign pk_b = (state_q == ST_DISC) ? partner_lanes : mask_q;

    ltc_lane_pick #(.N(NLANE)) u_pick (
        .a(pk_a), .b(pk_b), .both(pk_both), .cnt(pk_cnt),
        .low_idx(pk_low), .low_hot(pk_hot)
    );

    ltc_timer #(.TW(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_SEEK),
        .limit(seek_limit), .expired(tmr_exp)
    );

    assign wr_ctx = '{st: state_q, mask: mask_q, width: width_q, rate: rate_q};

    ltc_ctx_store #(.N(NPROTO)) u_ctx (
        .clk(clk), .rst_n(rst_n), .wr_en(save), .wr_idx(proto_q),
        .wr_ctx(wr_ctx), .rd_idx(proto_q), .rd_ctx(rd_ctx), .rd_ok(rd_ok)
    );

    assign lane_drop = (ts_seen & mask_q) != mask_q;
    assign rate_min  = (local_rate < partner_rate) ? local_rate : partner_rate;

    // Next-state and next-context decision.
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        width_d = width_q;
        rate_d  = rate_q;
        proto_d = proto_q;
        save    = 1'b0;
        case (state_q)
            ST_SILENT: state_d = ST_SEEK;
            ST_SEEK: begin
                if (|ts_seen)    state_d = ST_DISC;
                else if (tmr_exp) state_d = ST_SILENT;
            end
            ST_DISC: begin
                if (partner_valid) begin
                    if ((pk_cnt == '0) || (partner_rate == '0)) begin
                        state_d = ST_SILENT;
                    end else begin
                        rate_d = rate_min;
                        mask_d = pk_both;
                        if (pk_cnt == CNT_W'(NLANE)) begin
                            state_d = ST_X4;
                            width_d = WID_W'(NLANE);
                        end else if (pk_cnt >= CNT_W'(2)) begin
                            state_d = ST_X2;
                            width_d = WID_W'(2);
                        end else begin
                            state_d = ltc_state_e'(4'(ST_X1_L0) + 4'(pk_low));
                            width_d = WID_W'(1);
                        end
                    end
                end
            end
            ST_X4, ST_X2, ST_X1_L0, ST_X1_L1, ST_X1_L2, ST_X1_L3: begin
                if (lane_drop) begin
                    state_d = ((state_q == ST_X4) || (state_q == ST_X2)) ? ST_REC2 : ST_DISC;
                end else if (switch_req) begin
                    save    = 1'b1;
                    proto_d = ~proto_q;
                    state_d = ST_PLLRST;
                end
            end
            ST_REC2: begin
                mask_d = pk_both;
                if (pk_cnt >= CNT_W'(2)) begin
                    state_d = ST_X2;
                    width_d = WID_W'(2);
                end else begin
                    state_d = ST_REC1;
                end
            end
            ST_REC1: begin
                if (pk_cnt != '0) begin
                    state_d = ltc_state_e'(4'(ST_X1_L0) + 4'(pk_low));
                    mask_d  = pk_hot;
                    width_d = WID_W'(1);
                end else begin
                    state_d = ST_DISC;
                end
            end
            ST_PLLRST: state_d = ST_PLLWAIT;
            ST_PLLWAIT: begin
                if (pll_lock && !lock_q) begin
                    if (rd_ok) begin
                        state_d = rd_ctx.st;
                        mask_d  = rd_ctx.mask;
                        width_d = rd_ctx.width;
                        rate_d  = rd_ctx.rate;
                    end else begin
                        state_d = ST_SILENT;
                    end
                end
            end
            default: state_d = ST_SILENT;
        endcase
        if (state_d == ST_SILENT) begin
            mask_d  = '0;
            width_d = '0;
            rate_d  = '0;
        end
    end

    // State, context and lock-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SILENT;
            mask_q  <= '0;
            width_q <= '0;
            rate_q  <= '0;
            proto_q <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            width_q <= width_d;
            rate_q  <= rate_d;
            proto_q <= proto_d;
            lock_q  <= pll_lock;
        end
    end

    assign state_code   = state_q;
    assign link_width   = width_q;
    assign link_rate    = rate_q;
    assign pll_rst      = (state_q == ST_PLLRST);
    assign switch_en    = is_mode(state_q);
    assign active_proto = proto_q;
endmodule

// File: rtl/ltc_checker.sv
// Property checker for lane_train_ctrl, attached with bind. It only
// observes ports.
module ltc_checker
    import ltc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        state_code,
    input logic [WID_W-1:0]  link_width,
    input logic [RATE_W-1:0] link_rate,
    input logic              pll_rst,
    input logic              switch_en,
    input logic              pll_lock,
    input logic              active_proto
);
    a_r11_no_en_in_pll: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 4'd11) || (state_code == 4'd12)) |-> !switch_en);

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |=> (!pll_rst && (state_code == 4'd12)));

    a_r9_proto_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> (active_proto != $past(active_proto)));

    a_r12_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode(ltc_state_e'(state_code)) && (state_code == $past(state_code)))
        |-> ($stable(link_width) && $stable(link_rate)));

    a_r10_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_code) == 4'd12) && (state_code != 4'd12))
        |-> ($past(pll_lock) && !$past(pll_lock, 2)));

    a_r5_x4_width: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd3) |-> (link_width == 16'd4));

    a_r6_x1_width: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code >= 4'd5) && (state_code <= 4'd8)) |-> (link_width == 16'd1));

    a_r3_seek_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd1) |=> (state_code <= 4'd2));
endmodule

bind lane_train_ctrl ltc_checker u_ltc_chk (
    .clk(clk), .rst_n(rst_n), .state_code(state_code), .link_width(link_width),
    .link_rate(link_rate), .pll_rst(pll_rst), .switch_en(switch_en),
    .pll_lock(pll_lock), .active_proto(active_proto)
);

// File: tb/tb_lane_train_ctrl.sv
// Directed bench for lane_train_ctrl: one task per scenario.
module tb_lane_train_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ts_seen = '0;
    logic [3:0]  local_lanes = 4'hF;
    logic [3:0]  local_rate = 4'd3;
    logic        partner_valid = 1'b0;
    logic [3:0]  partner_lanes = 4'hF;
    logic [3:0]  partner_rate = 4'd2;
    logic [15:0] seek_limit = 16'd20;
    logic        switch_req = 1'b0;
    logic        pll_lock = 1'b1;
    logic [3:0]  state_code;
    logic [15:0] link_width;
    logic [3:0]  link_rate;
    logic        pll_rst;
    logic        switch_en;
    logic        active_proto;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lane_train_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ts_seen(ts_seen), .local_lanes(local_lanes),
        .local_rate(local_rate), .partner_valid(partner_valid),
        .partner_lanes(partner_lanes), .partner_rate(partner_rate),
        .seek_limit(seek_limit), .switch_req(switch_req), .pll_lock(pll_lock),
        .state_code(state_code), .link_width(link_width), .link_rate(link_rate),
        .pll_rst(pll_rst), .switch_en(switch_en), .active_proto(active_proto)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] ts);
        rst_n = 1'b0;
        ts_seen = ts; local_lanes = 4'hF; local_rate = 4'd3;
        partner_valid = 1'b0; partner_lanes = 4'hF; partner_rate = 4'd2;
        seek_limit = 16'd20; switch_req = 1'b0; pll_lock = 1'b1;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic wait_state(input int code, input string tag);
        int i = 0;
        while ((state_code != 4'(code)) && (i < 50)) begin
            step(1);
            i++;
        end
        check(tag, state_code, code);
    endtask

    // Reset until discovery, then present the advertisement for one clock.
    task automatic train(input logic [3:0] loc, input logic [3:0] par, input logic [3:0] prate,
                         input int exp_st, input int exp_w, input int exp_r, input string tag);
        do_reset(4'hF);
        local_lanes = loc; partner_lanes = par; partner_rate = prate;
        wait_state(2, {tag, " reach discovery"});
        partner_valid = 1'b1;
        step(1);
        check({tag, " state"}, state_code, exp_st);
        check({tag, " width"}, link_width, exp_w);
        check({tag, " rate"}, link_rate, exp_r);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(2);
        check("R1 state", state_code, 0);
        check("R1 width", link_width, 0);
        check("R1 rate", link_rate, 0);
        check("R1 strobe", pll_rst, 0);
        check("R1 switch_en", switch_en, 0);
        check("R1 proto", active_proto, 0);
    endtask

    task automatic t_seek_echo;
        do_reset(4'b0100);
        check("R1 state after release", state_code, 0);
        step(1);
        check("R2 quiet then seek", state_code, 1);
        step(1);
        check("R2 echo to discovery", state_code, 2);
    endtask

    task automatic t_timeout;
        int cnt = 0;
        do_reset(4'h0);
        seek_limit = 16'd5;
        step(1);
        while (state_code == 4'd1 && cnt < 40) begin
            cnt++;
            step(1);
        end
        check("R3 seek cycles", cnt, 6);
        check("R3 back to quiet", state_code, 0);
    endtask

    task automatic t_widths;
        train(4'hF, 4'hF, 4'd2, 3, 4, 2, "R5 four lanes");
        check("R11 enable in mode", switch_en, 1);
        train(4'hF, 4'b0111, 4'd5, 4, 2, 3, "R5 three common");
        train(4'b1110, 4'b0110, 4'd1, 4, 2, 1, "R5 two common");
        train(4'hF, 4'b0001, 4'd2, 5, 1, 2, "R6 lane0");
        train(4'b0110, 4'b0011, 4'd2, 6, 1, 2, "R6 lane1");
        train(4'b0100, 4'hF, 4'd2, 7, 1, 2, "R6 lane2");
        train(4'b1010, 4'b1000, 4'd2, 8, 1, 2, "R6 lane3");
        train(4'b0011, 4'b1100, 4'd2, 0, 0, 0, "R4 disjoint");
        train(4'hF, 4'hF, 4'd0, 0, 0, 0, "R4 zero rate");
    endtask

    task automatic t_recovery;
        train(4'hF, 4'hF, 4'd2, 3, 4, 2, "R7 setup");
        partner_valid = 1'b0;
        ts_seen = 4'b1110;
        step(1);
        check("R7 to two-lane recovery", state_code, 9);
        step(1);
        check("R7 back to two-lane", state_code, 4);
        check("R7 width", link_width, 2);
        check("R12 rate kept", link_rate, 2);
        ts_seen = 4'b0100;
        step(1);
        check("R7 recovery again", state_code, 9);
        step(1);
        check("R7 to single recovery", state_code, 10);
        step(1);
        check("R8 lowest live lane", state_code, 7);
        check("R8 width", link_width, 1);
        ts_seen = 4'h0;
        step(1);
        check("R8 single lost to discovery", state_code, 2);
    endtask

    task automatic t_ignore_switch;
        do_reset(4'hF);
        wait_state(2, "R9 reach discovery");
        switch_req = 1'b1;
        step(2);
        check("R9 ignored state", state_code, 2);
        check("R9 ignored strobe", pll_rst, 0);
        check("R9 ignored proto", active_proto, 0);
        switch_req = 1'b0;
    endtask

    task automatic t_hold;
        train(4'hF, 4'hF, 4'd2, 3, 4, 2, "R12 setup");
        partner_lanes = 4'b0001; partner_rate = 4'd1; local_rate = 4'd1;
        step(3);
        check("R12 state", state_code, 3);
        check("R12 width", link_width, 4);
        check("R12 rate", link_rate, 2);
    endtask

    task automatic switch_to(input int exp_proto, input string tag);
        switch_req = 1'b1;
        step(1);
        check({tag, " R9 reset state"}, state_code, 11);
        check({tag, " R9 strobe"}, pll_rst, 1);
        check({tag, " R11 enable low"}, switch_en, 0);
        check({tag, " R9 proto"}, active_proto, exp_proto);
        switch_req = 1'b0;
        pll_lock = 1'b0;
        step(1);
        check({tag, " R9 wait state"}, state_code, 12);
        check({tag, " R9 strobe low"}, pll_rst, 0);
        step(2);
        check({tag, " R9 still waiting"}, state_code, 12);
        check({tag, " R11 enable low wait"}, switch_en, 0);
    endtask

    task automatic t_switch;
        train(4'hF, 4'hF, 4'd2, 3, 4, 2, "R10 proto0");
        switch_to(1, "first");
        local_lanes = 4'b0011; partner_rate = 4'd1;
        pll_lock = 1'b1;
        step(1);
        check("R10 untrained to quiet", state_code, 0);
        wait_state(4, "R10 proto1 trained");
        check("R10 proto1 width", link_width, 2);
        check("R10 proto1 rate", link_rate, 1);
        switch_to(0, "second");
        pll_lock = 1'b1;
        step(1);
        check("R10 restore proto0 state", state_code, 3);
        check("R10 restore proto0 width", link_width, 4);
        check("R10 restore proto0 rate", link_rate, 2);
        check("R11 enable after restore", switch_en, 1);
        switch_to(1, "third");
        pll_lock = 1'b1;
        step(1);
        check("R10 restore proto1 state", state_code, 4);
        check("R10 restore proto1 width", link_width, 2);
        check("R10 restore proto1 rate", link_rate, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(1);
        t_reset;
        t_seek_echo;
        t_timeout;
        t_widths;
        t_recovery;
        t_ignore_switch;
        t_hold;
        t_switch;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule